// File: doc/BRIEF.md
# DMA Completion Response Queue

This block sits between a DMA engine and a host register bus. Each time the engine retires a descriptor it presents one completion record: a 32-bit count of bytes moved, an 8-bit error code and an early-termination flag. The block queues these records in arrival order, and the host drains them through two read-only words.

The host first reads the byte-count word of the oldest record, then its status word. The status read retires the record, but only when the byte-count read of that same record came first. A status read that is not preceded by a byte-count read returns the data and leaves the queue unchanged. The fill level, empty and full flags tell the host how many records to drain. An overflow flag records, until reset, that a completion arrived while the queue was full and was lost.

Read data is registered. It appears on `rdData` in the cycle after the read strobe and holds until the next read.

Top module: `dma_resp_queue`

## Requirements
- R1: After reset, `empty` is 1, `full` is 0, `fillLevel` is 0, `overflow` is 0 and `rdData` is 0.
- R2: A push accepted on a clock edge raises `fillLevel` by one after that edge. Records are returned in the order they were pushed.
- R3: A read at offset 0x0 while the queue holds a record places that record's byte count on `rdData` after the next edge.
- R4: A read at offset 0x4 while the queue holds a record returns the status word on `rdData` after the next edge. The error code is in bits 7:0, early termination is in bit 8, and bits 31:9 are zero.
- R5: A status read retires the head record only if a byte-count read happened since the last retirement. Otherwise it returns the data and `fillLevel` does not change. A byte-count read never retires a record.
- R6: A read of either word while the queue is empty returns zero and changes neither the level nor the byte-count-read state.
- R7: A read at any offset other than 0x0 or 0x4 returns zero, retires nothing, and does not count as a byte-count read.
- R8: A push that arrives while `full` is 1 is discarded, even if a retirement happens in the same cycle, and it sets `overflow`. `overflow` then stays 1 until reset.
- R9: A push and a retirement on the same edge are both carried out, so `fillLevel` is unchanged and the new record sits behind the remaining ones.
- R10: `empty` is 1 exactly when `fillLevel` is 0. `full` is 1 exactly when `fillLevel` equals DEPTH.
- R11: While `rdEn` is low, `rdData` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pushValid | input | 1 | Engine presents a completion record this cycle |
| pushBytes | input | 32 | Byte count of the record |
| pushErr | input | 8 | Error code of the record |
| pushEarly | input | 1 | Record ended early |
| rdEn | input | 1 | Host read strobe |
| rdAddr | input | ADDR_W (3) | Byte offset of the read: 0x0 byte count, 0x4 status |
| rdData | output | 32 | Registered read data |
| fillLevel | output | CNT_W (4) | Number of queued records |
| empty | output | 1 | Queue holds no record |
| full | output | 1 | Queue holds DEPTH records |
| overflow | output | 1 | Sticky: a record was discarded |

## Verification
The bench goes after the pop-gating rule by issuing status reads without a prior byte-count read, repeated byte-count reads, and reads at stray offsets. A design that popped on every status read, or that let a stray offset arm the pop, would show `fillLevel` falling too early and would then return the wrong record. The bench fills the queue past DEPTH, including a push in the same cycle as a pop while full, to catch a design that accepts the extra record or does not hold the overflow flag. It also reads while the queue is empty, where a design that read stale storage would return non-zero data, and it pushes and pops together to expose a level counter that drops one of the two updates.

// File: rtl/dma_resp_queue_pkg.sv
package dma_resp_queue_pkg;

  localparam int STAT_W = 9;   // error code 8 bits + early flag

  typedef struct packed {
    logic push;       // store the incoming record at the tail
    logic pop;        // retire the head record
    logic rdBytes;    // load head byte count into read register
    logic rdStatus;   // load head status into read register
    logic rdZero;     // load zero into read register
  } respStrb_t;

endpackage

// File: rtl/dma_resp_queue_ctrl.sv
module dma_resp_queue_ctrl
  import dma_resp_queue_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 3,
  parameter int CNT_W  = $clog2(DEPTH + 1),
  parameter logic [ADDR_W-1:0] OFS_BYTES  = 'h0,
  parameter logic [ADDR_W-1:0] OFS_STATUS = 'h4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pushValid,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output respStrb_t         strb,
  output logic [CNT_W-1:0]  fillLevel,
  output logic              empty,
  output logic              full,
  output logic              overflow
);

  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [CNT_W-1:0] count;
  logic             armed;
  logic             hasHead;

  assign hasHead = (count != '0);

  always_comb begin
    strb          = '0;
    strb.rdBytes  = rdEn && hasHead && (rdAddr == OFS_BYTES);
    strb.rdStatus = rdEn && hasHead && (rdAddr == OFS_STATUS);
    strb.rdZero   = rdEn && !(strb.rdBytes || strb.rdStatus);
    strb.pop      = strb.rdStatus && armed;
    strb.push     = pushValid && (count != CNT_FULL);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count    <= '0;
      armed    <= 1'b0;
      overflow <= 1'b0;
    end else begin
      case ({strb.push, strb.pop})
        2'b10:   count <= count + CNT_ONE;
        2'b01:   count <= count - CNT_ONE;
        default: count <= count;
      endcase
      if (strb.pop)
        armed <= 1'b0;
      else if (strb.rdBytes)
        armed <= 1'b1;
      if (pushValid && (count == CNT_FULL))
        overflow <= 1'b1;
    end
  end

  assign fillLevel = count;
  assign empty     = !hasHead;
  assign full      = (count == CNT_FULL);

endmodule

// File: rtl/dma_resp_queue_dp.sv
module dma_resp_queue_dp
  import dma_resp_queue_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  respStrb_t   strb,
  input  logic [31:0] pushBytes,
  input  logic [7:0]  pushErr,
  input  logic        pushEarly,
  output logic [31:0] rdData
);

  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [PTR_W-1:0] PTR_ONE  = PTR_W'(1);

  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdPtr;
  logic [31:0]       slotBytes [DEPTH];
  logic [STAT_W-1:0] slotStat  [DEPTH];

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + PTR_ONE;
  endfunction

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
    always_ff @(posedge clk) begin
      if (strb.push && (wrPtr == PTR_W'(gi))) begin
        slotBytes[gi] <= pushBytes;
        slotStat[gi]  <= {pushEarly, pushErr};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      rdData <= '0;
    end else begin
      if (strb.push) wrPtr <= nextPtr(wrPtr);
      if (strb.pop)  rdPtr <= nextPtr(rdPtr);
      if (strb.rdBytes)
        rdData <= slotBytes[rdPtr];
      else if (strb.rdStatus)
        rdData <= {{(32 - STAT_W){1'b0}}, slotStat[rdPtr]};
      else if (strb.rdZero)
        rdData <= '0;
    end
  end

endmodule

// File: rtl/dma_resp_queue.sv
module dma_resp_queue
  import dma_resp_queue_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 3,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pushValid,
  input  logic [31:0]       pushBytes,
  input  logic [7:0]        pushErr,
  input  logic              pushEarly,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [31:0]       rdData,
  output logic [CNT_W-1:0]  fillLevel,
  output logic              empty,
  output logic              full,
  output logic              overflow
);

  respStrb_t strb;

  dma_resp_queue_ctrl #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .rdEn(rdEn),
    .rdAddr(rdAddr), .strb(strb), .fillLevel(fillLevel),
    .empty(empty), .full(full), .overflow(overflow)
  );

  dma_resp_queue_dp #(
    .DEPTH(DEPTH)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .pushBytes(pushBytes),
    .pushErr(pushErr), .pushEarly(pushEarly), .rdData(rdData)
  );

endmodule

// File: rtl/dma_resp_queue_chk.sv
module dma_resp_queue_chk #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 3,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              pushValid,
  input logic              rdEn,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [31:0]       rdData,
  input logic [CNT_W-1:0]  fillLevel,
  input logic              empty,
  input logic              full,
  input logic              overflow
);

  localparam logic [ADDR_W-1:0] A_BYTES  = ADDR_W'('h0);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'('h4);

  AST_BYTE_READ_NO_POP: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rdAddr == A_BYTES && !pushValid) |=> fillLevel == $past(fillLevel)); // R5

  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && empty) |=> rdData == 32'h0); // R6

  AST_STATUS_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rdAddr == A_STATUS) |=> rdData[31:9] == '0); // R4

  AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow); // R8

  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (full && pushValid && !rdEn) |=> (full && overflow)); // R8

  AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData)); // R11

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (32'(fillLevel) <= DEPTH) && (full -> !empty)); // R10

endmodule

bind dma_resp_queue dma_resp_queue_chk #(
  .DEPTH(DEPTH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rstN(rstN), .pushValid(pushValid), .rdEn(rdEn),
  .rdAddr(rdAddr), .rdData(rdData), .fillLevel(fillLevel),
  .empty(empty), .full(full), .overflow(overflow)
);

// File: tb/dma_resp_queue_tb.sv
module dma_resp_queue_tb;

  localparam int DEPTH  = 8;
  localparam int ADDR_W = 3;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              pushValid = 1'b0;
  logic [31:0]       pushBytes = '0;
  logic [7:0]        pushErr = '0;
  logic              pushEarly = 1'b0;
  logic              rdEn = 1'b0;
  logic [ADDR_W-1:0] rdAddr = '0;
  logic [31:0]       rdData;
  logic [CNT_W-1:0]  fillLevel;
  logic              empty, full, overflow;

  always #2 clk = ~clk;  // 250 MHz

  dma_resp_queue #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .pushBytes(pushBytes),
    .pushErr(pushErr), .pushEarly(pushEarly), .rdEn(rdEn), .rdAddr(rdAddr),
    .rdData(rdData), .fillLevel(fillLevel), .empty(empty), .full(full),
    .overflow(overflow)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // reference model
  logic [31:0] mBytes[$];
  logic [8:0]  mStat[$];
  bit          mArmed = 0;
  bit          mOvf = 0;
  logic [31:0] mRd = '0;

  task automatic checkEq(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic string dataTag(bit re, logic [ADDR_W-1:0] a, int cnt);
    if (!re) return "R11";
    if (cnt == 0) return "R6";
    if (a == 3'h0) return "R3";
    if (a == 3'h4) return "R4";
    return "R7";
  endfunction

  // One clock: drive at negedge, check after the edge.
  task automatic step(bit pv, logic [31:0] pb, logic [7:0] pe, bit pl,
                      bit re, logic [ADDR_W-1:0] a, string lvlTag);
    int cnt;
    bit pop;
    string dt;
    cnt = mBytes.size();
    dt = dataTag(re, a, cnt);
    pushValid = pv; pushBytes = pb; pushErr = pe; pushEarly = pl;
    rdEn = re; rdAddr = a;
    if (re) begin
      if (cnt == 0)       mRd = '0;
      else if (a == 3'h0) mRd = mBytes[0];
      else if (a == 3'h4) mRd = {23'h0, mStat[0]};
      else                mRd = '0;
    end
    pop = re && (cnt != 0) && (a == 3'h4) && mArmed;
    if (pop) begin
      mArmed = 0;
      void'(mBytes.pop_front());
      void'(mStat.pop_front());
    end else if (re && (cnt != 0) && (a == 3'h0)) mArmed = 1;
    if (pv) begin
      if (cnt == DEPTH) mOvf = 1;
      else begin
        mBytes.push_back(pb);
        mStat.push_back({pl, pe});
      end
    end
    @(posedge clk); #1;
    checkEq(dt, "rdData", rdData, mRd);
    checkEq(lvlTag, "fillLevel", 32'(fillLevel), 32'(mBytes.size()));
    checkEq("R10", "empty", 32'(empty), 32'(mBytes.size() == 0));
    checkEq("R10", "full", 32'(full), 32'(mBytes.size() == DEPTH));
    checkEq("R8", "overflow", 32'(overflow), 32'(mOvf));
    @(negedge clk);
    pushValid = 0; rdEn = 0;
  endtask

  task automatic idle(); step(0, 0, 0, 0, 0, 0, "R2"); endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion (all requirements)");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rstN = 1;
    #0;
    // R1 reset state
    checkEq("R1", "empty", 32'(empty), 1);
    checkEq("R1", "full", 32'(full), 0);
    checkEq("R1", "fillLevel", 32'(fillLevel), 0);
    checkEq("R1", "overflow", 32'(overflow), 0);
    checkEq("R1", "rdData", rdData, 0);

    // R6 empty reads, then a push must not be poppable by a stale arm
    step(0, 0, 0, 0, 1, 3'h0, "R6");
    step(0, 0, 0, 0, 1, 3'h4, "R6");
    step(1, 32'h1111_0001, 8'h5A, 1, 0, 0, "R2");
    step(1, 32'h2222_0002, 8'h00, 0, 0, 0, "R2");
    // R5 status read without byte read: no pop
    step(0, 0, 0, 0, 1, 3'h4, "R5");
    // R7 stray offset does not arm
    step(0, 0, 0, 0, 1, 3'h2, "R7");
    step(0, 0, 0, 0, 1, 3'h4, "R5");
    // R5 byte read twice then status pops once
    step(0, 0, 0, 0, 1, 3'h0, "R5");
    step(0, 0, 0, 0, 1, 3'h0, "R5");
    step(0, 0, 0, 0, 1, 3'h4, "R5");
    step(0, 0, 0, 0, 1, 3'h4, "R5");
    idle();
    // R9 push together with pop
    step(0, 0, 0, 0, 1, 3'h0, "R9");
    step(1, 32'h3333_0003, 8'hFF, 1, 1, 3'h4, "R9");
    step(0, 0, 0, 0, 1, 3'h0, "R2");
    step(0, 0, 0, 0, 1, 3'h4, "R2");

    // R8 fill past DEPTH, including push+pop while full
    for (int i = 0; i < DEPTH + 2; i++)
      step(1, 32'hA000_0000 + 32'(i), 8'(i), i[0], 0, 0, "R8");
    step(0, 0, 0, 0, 1, 3'h0, "R8");
    step(1, 32'hDEAD_BEEF, 8'h77, 1, 1, 3'h4, "R8");
    for (int i = 0; i < DEPTH; i++) begin
      step(0, 0, 0, 0, 1, 3'h0, "R2");
      step(0, 0, 0, 0, 1, 3'h4, "R2");
    end
    step(0, 0, 0, 0, 1, 3'h0, "R6");

    // Constrained random phases with varying push/read bias
    for (int ph = 0; ph < 6; ph++) begin
      for (int n = 0; n < 1500; n++) begin
        int pp, rp, ar;
        logic [ADDR_W-1:0] a;
        pp = (ph % 3 == 0) ? 70 : (ph % 3 == 1) ? 30 : 50;
        rp = (ph % 3 == 0) ? 40 : 80;
        ar = $urandom_range(0, 9);
        a = (ar < 5) ? 3'h0 : (ar < 9) ? 3'h4 : ADDR_W'($urandom_range(0, 7));
        step(($urandom_range(0, 99) < pp), $urandom, 8'($urandom), 1'($urandom),
             ($urandom_range(0, 99) < rp), a, "R2");
      end
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule